// File: doc/BRIEF.md
# Store-Gathering Write Queue

This block sits behind a store-through cache and in front of the next memory level. Each cycle it can take one store of up to eight bytes, with a byte enable per lane. A store is never held back as dirty cache state; it is placed in the queue at once. While a queue entry waits for the downstream port, later stores that fall in the same 128-byte line are folded into that entry. The line then leaves as one masked line write instead of one write per store.

Each entry holds a line number, a full line of data bytes and a per-byte valid mask. Entries leave in the order they were opened. The oldest entry moves into an output register that drives the write port. Once an entry is in that register it is draining, and it no longer accepts merges. Flow control on the store side looks at the store being offered: a store that hits a waiting entry is always taken, and a store to a new line is refused only when every entry is in use.

Top module: `store_gather_queue`

## Requirements
- R1: `st_addr` is a byte address. Its bits [6:3] select the 8-byte slot within the 128-byte line, and the bits above bit 6 give the line number placed on `wr_line`. Bits [2:0] are ignored. Bit i of `st_be` enables store byte `st_data[8i+7:8i]`, which lands on line byte slot*8+i. Line byte b is carried on `wr_data[8b+7:8b]` and is flagged by `wr_mask[b]`.
- R2: A store accepted into an empty queue while `wr_ready` is high leaves as exactly one write. That write carries the store's line number, and its mask is exactly the enabled bytes. Data bytes whose mask bit is clear carry no meaning.
- R3: Stores to the same line accepted while that line's entry is still waiting are merged into one entry. The entry's mask is the union of their enabled bytes.
- R4: Where a merged store overlaps bytes already held, the newer store's bytes replace the older ones.
- R5: A store to a line whose entry is already on the write port (draining) does not change that write. It opens a new entry, which leaves later as a separate write.
- R6: A store accepted in the same cycle that its line's entry moves to the write port is included in that write.
- R7: Writes leave in the order their entries were opened. While `wr_valid` is high and `wr_ready` is low, `wr_line`, `wr_mask` and `wr_data` hold steady.
- R8: `full` is high when all DEPTH entries (default 4) are waiting. While full, `st_ready` is low for a store to a line with no waiting entry, and high for a store that hits a waiting entry. A refused store leaves no trace in later writes.
- R9: After reset, `empty` is 1, `full` is 0, `wr_valid` is 0 and `st_ready` is 1. `empty` is high only when no entry is waiting and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W (32) | Store byte address |
| st_data | input | STORE_BYTES*8 (64) | Store data, lane i in bits [8i+7:8i] |
| st_be | input | STORE_BYTES (8) | Per-lane byte enables |
| wr_valid | output | 1 | Line write pending |
| wr_ready | input | 1 | Downstream accepts the write |
| wr_line | output | ADDR_W-7 (25) | Line number of the write |
| wr_data | output | LINE_BYTES*8 (1024) | Line data |
| wr_mask | output | LINE_BYTES (128) | Per-byte valid mask |
| empty | output | 1 | Nothing queued or pending |
| full | output | 1 | All entries in use |

## Verification
The first pattern is a lone store with a sparse byte enable and a non-zero low address. It separates correct slot and lane placement from a shifted or mirrored mapping. Two stores to one line on back-to-back cycles, with the port free, tell apart a design that folds a store into the entry moving out that cycle from one that emits two writes. With the port stalled, a mix of overlapping, disjoint and already-draining same-line stores checks the newest-wins rule, the mask union, and the rule that a draining entry accepts no merge. A fill to capacity then checks that a new-line store is refused, that a store to a waiting line is still accepted, and that writes drain in allocation order.

// File: rtl/sgq_pkg.sv
package sgq_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_ALLOC = 2'd1,
    ACT_MERGE = 2'd2
  } store_act_e;
endpackage

// File: rtl/sgq_lane_expand.sv
// Spreads one narrow store across a full line: byte enables land on the
// selected slot, data is replicated to every slot (the enables pick it).
module sgq_lane_expand #(
  parameter int unsigned LINE_BYTES  = 128,
  parameter int unsigned STORE_BYTES = 8,
  parameter int unsigned SLOT_W      = 4
) (
  input  logic [SLOT_W-1:0]          slot,
  input  logic [STORE_BYTES*8-1:0]   st_data,
  input  logic [STORE_BYTES-1:0]     st_be,
  output logic [LINE_BYTES-1:0]      line_be,
  output logic [LINE_BYTES*8-1:0]    line_data
);
  localparam int unsigned SLOTS = LINE_BYTES / STORE_BYTES;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign line_be[s*STORE_BYTES +: STORE_BYTES] =
      (slot == SLOT_W'(s)) ? st_be : '0;
    assign line_data[s*STORE_BYTES*8 +: STORE_BYTES*8] = st_data;
  end
endmodule

// File: rtl/sgq_tag_match.sv
// Compares the incoming line number against every waiting entry.
module sgq_tag_match #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 25,
  parameter int unsigned PTR_W = 2
) (
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic [DEPTH-1:0]            vld,
  input  logic [TAG_W-1:0]            probe,
  output logic [DEPTH-1:0]            hit_vec,
  output logic                        hit,
  output logic [PTR_W-1:0]            hit_idx
);
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_vec[i] = vld[i] && (tags[i] == probe);
      if (hit_vec[i]) hit_idx = PTR_W'(i);
    end
    hit = |hit_vec;
  end
endmodule

// File: rtl/sgq_entry_ram.sv
// Line data storage with per-byte write enables, one write and one read port.
module sgq_entry_ram #(
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned LINE_BYTES = 128,
  parameter int unsigned PTR_W      = 2
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [PTR_W-1:0]          waddr,
  input  logic [LINE_BYTES-1:0]     wbe,
  input  logic [LINE_BYTES*8-1:0]   wdata,
  input  logic [PTR_W-1:0]          raddr,
  output logic [LINE_BYTES*8-1:0]   rdata
);
  logic [LINE_BYTES*8-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (wbe[b]) mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sgq_drain_reg.sv
// Output register for the line write port.
module sgq_drain_reg #(
  parameter int unsigned LINE_BYTES = 128,
  parameter int unsigned TAG_W      = 25
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [TAG_W-1:0]         in_line,
  input  logic [LINE_BYTES*8-1:0]  in_data,
  input  logic [LINE_BYTES-1:0]    in_mask,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [TAG_W-1:0]         out_line,
  output logic [LINE_BYTES*8-1:0]  out_data,
  output logic [LINE_BYTES-1:0]    out_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_line <= in_line;
      out_data <= in_data;
      out_mask <= in_mask;
    end
  end

  // R7: a stalled write keeps its contents
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_line) &&
                                   $stable(out_mask) && $stable(out_data)));
endmodule

// File: rtl/store_gather_queue.sv
module store_gather_queue #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LINE_BYTES  = 128,
  parameter int unsigned STORE_BYTES = 8,
  parameter int unsigned DEPTH       = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            st_valid,
  output logic                            st_ready,
  input  logic [ADDR_W-1:0]               st_addr,
  input  logic [STORE_BYTES*8-1:0]        st_data,
  input  logic [STORE_BYTES-1:0]          st_be,
  output logic                            wr_valid,
  input  logic                            wr_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] wr_line,
  output logic [LINE_BYTES*8-1:0]         wr_data,
  output logic [LINE_BYTES-1:0]           wr_mask,
  output logic                            empty,
  output logic                            full
);
  import sgq_pkg::*;

  localparam int unsigned OFS_W    = $clog2(LINE_BYTES);
  localparam int unsigned SLOT_LSB = $clog2(STORE_BYTES);
  localparam int unsigned SLOT_W   = OFS_W - SLOT_LSB;
  localparam int unsigned TAG_W    = ADDR_W - OFS_W;
  localparam int unsigned LINE_W   = LINE_BYTES * 8;
  localparam int unsigned PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  // entry state
  logic [DEPTH-1:0]             ent_vld;
  logic [DEPTH-1:0][TAG_W-1:0]  ent_tag;
  logic [DEPTH-1:0][LINE_BYTES-1:0] ent_mask;
  logic [PTR_W-1:0]             head, tail;
  logic [CNT_W-1:0]             cnt;

  // store decode
  logic [TAG_W-1:0]   st_tag;
  logic [SLOT_W-1:0]  st_slot;
  logic [LINE_BYTES-1:0] line_be;
  logic [LINE_W-1:0]  line_data;

  assign st_tag  = st_addr[ADDR_W-1:OFS_W];
  assign st_slot = st_addr[OFS_W-1:SLOT_LSB];

  sgq_lane_expand #(
    .LINE_BYTES (LINE_BYTES),
    .STORE_BYTES(STORE_BYTES),
    .SLOT_W     (SLOT_W)
  ) u_expand (
    .slot     (st_slot),
    .st_data  (st_data),
    .st_be    (st_be),
    .line_be  (line_be),
    .line_data(line_data)
  );

  logic [DEPTH-1:0] hit_vec;
  logic             hit;
  logic [PTR_W-1:0] hit_idx;

  sgq_tag_match #(
    .DEPTH(DEPTH),
    .TAG_W(TAG_W),
    .PTR_W(PTR_W)
  ) u_match (
    .tags   (ent_tag),
    .vld    (ent_vld),
    .probe  (st_tag),
    .hit_vec(hit_vec),
    .hit    (hit),
    .hit_idx(hit_idx)
  );

  // control
  store_act_e       act;
  logic             st_fire;
  logic             pop;
  logic             merge_head;
  logic [PTR_W-1:0] wr_idx;

  assign st_ready = hit || (cnt != CNT_FULL);
  assign st_fire  = st_valid && st_ready;
  assign pop      = (cnt != '0) && (!wr_valid || wr_ready);

  always_comb begin
    if (!st_fire)  act = ACT_IDLE;
    else if (hit)  act = ACT_MERGE;
    else           act = ACT_ALLOC;
  end

  assign wr_idx     = (act == ACT_MERGE) ? hit_idx : tail;
  assign merge_head = (act == ACT_MERGE) && (hit_idx == head);

  // data storage
  logic [LINE_W-1:0] head_rdata;

  sgq_entry_ram #(
    .DEPTH     (DEPTH),
    .LINE_BYTES(LINE_BYTES),
    .PTR_W     (PTR_W)
  ) u_ram (
    .clk  (clk),
    .we   (st_fire),
    .waddr(wr_idx),
    .wbe  (line_be),
    .wdata(line_data),
    .raddr(head),
    .rdata(head_rdata)
  );

  // head view with a same-cycle merge folded in
  logic [LINE_W-1:0]     head_data_m;
  logic [LINE_BYTES-1:0] head_mask_m;

  always_comb begin
    head_mask_m = ent_mask[head] | (merge_head ? line_be : '0);
    for (int b = 0; b < LINE_BYTES; b++) begin
      head_data_m[b*8 +: 8] = (merge_head && line_be[b]) ?
                              line_data[b*8 +: 8] : head_rdata[b*8 +: 8];
    end
  end

  // entry bookkeeping
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop && head == PTR_W'(i)) ent_vld[i] <= 1'b0;
        if (act == ACT_ALLOC && tail == PTR_W'(i)) ent_vld[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (act == ACT_ALLOC && tail == PTR_W'(i)) begin
        ent_tag[i]  <= st_tag;
        ent_mask[i] <= line_be;
      end else if (act == ACT_MERGE && hit_idx == PTR_W'(i)) begin
        ent_mask[i] <= ent_mask[i] | line_be;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (pop) head <= (head == PTR_LAST) ? '0 : head + PTR_W'(1);
      if (act == ACT_ALLOC) tail <= (tail == PTR_LAST) ? '0 : tail + PTR_W'(1);
      case ({act == ACT_ALLOC, pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  sgq_drain_reg #(
    .LINE_BYTES(LINE_BYTES),
    .TAG_W     (TAG_W)
  ) u_drain (
    .clk      (clk),
    .rst      (rst),
    .load     (pop),
    .in_line  (ent_tag[head]),
    .in_data  (head_data_m),
    .in_mask  (head_mask_m),
    .out_ready(wr_ready),
    .out_valid(wr_valid),
    .out_line (wr_line),
    .out_data (wr_data),
    .out_mask (wr_mask)
  );

  assign full  = (cnt == CNT_FULL);
  assign empty = (cnt == '0) && !wr_valid;

  // R8: occupancy never passes the entry count
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);

  // R8: the counter agrees with the per-entry valid flags
  a_r8_cnt_matches_vld: assert property (@(posedge clk) disable iff (rst)
    $countones(ent_vld) == int'(cnt));

  // R3: a line is held by at most one waiting entry
  a_r3_single_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R7: moving an entry out always presents a write next cycle
  a_r7_pop_presents: assert property (@(posedge clk) disable iff (rst)
    pop |=> wr_valid);

  // R9: reported empty means nothing is pending on the port
  a_r9_empty_idle: assert property (@(posedge clk) disable iff (rst)
    empty |-> (!wr_valid && ent_vld == '0));
endmodule

// File: tb/store_gather_queue_tb.sv
`timescale 1ns/1ps
module store_gather_queue_tb;
  localparam int ADDR_W = 32;
  localparam int LB     = 128;
  localparam int TAG_W  = ADDR_W - 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_valid = 1'b0;
  logic st_ready;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_be = '0;
  logic wr_valid;
  logic wr_ready = 1'b0;
  logic [TAG_W-1:0] wr_line;
  logic [LB*8-1:0]  wr_data;
  logic [LB-1:0]    wr_mask;
  logic empty, full;

  always #4 clk = ~clk;

  store_gather_queue u_dut (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_line(wr_line),
    .wr_data(wr_data), .wr_mask(wr_mask),
    .empty(empty), .full(full)
  );

  int total = 0;
  int bad   = 0;

  // captured writes
  logic [TAG_W-1:0] cap_line [64];
  logic [LB*8-1:0]  cap_data [64];
  logic [LB-1:0]    cap_mask [64];
  int ncap = 0;

  always @(negedge clk) begin
    if (!rst && wr_valid && wr_ready && ncap < 64) begin
      cap_line[ncap] = wr_line;
      cap_data[ncap] = wr_data;
      cap_mask[ncap] = wr_mask;
      ncap++;
    end
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] line, input int slot, input int lo);
    return {line, 4'(slot), 3'(lo)};
  endfunction

  function automatic logic [LB*8-1:0] bmask(input logic [LB-1:0] m);
    logic [LB*8-1:0] r;
    for (int b = 0; b < LB; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  task automatic add_exp(inout logic [LB*8-1:0] d, inout logic [LB-1:0] m,
                         input logic [ADDR_W-1:0] a, input logic [63:0] sd, input logic [7:0] be);
    int slot = int'(a[6:3]);
    for (int i = 0; i < 8; i++) begin
      if (be[i]) begin
        d[(slot*8+i)*8 +: 8] = sd[i*8 +: 8];
        m[slot*8+i] = 1'b1;
      end
    end
  endtask

  task automatic put(input logic [ADDR_W-1:0] a, input logic [63:0] d, input logic [7:0] be);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    @(negedge clk);
    while (!st_ready) @(negedge clk);
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic drain();
    wr_ready = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (empty) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic chk_wr(input string tag, input int k, input logic [TAG_W-1:0] line,
                        input logic [LB*8-1:0] d, input logic [LB-1:0] m);
    if (k >= ncap) begin
      total++; bad++;
      $display("FAIL %s missing write %0d actual=%0d expected>%0d", tag, k, ncap, k);
      return;
    end
    check({tag, " line"}, 128'(cap_line[k]), 128'(line));
    check({tag, " mask"}, cap_mask[k], m);
    check({tag, " data"}, 128'((cap_data[k] & bmask(m)) == (d & bmask(m))), 128'(1));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 empty after reset", 128'(empty), 128'(1));
    check("R9 full after reset", 128'(full), 128'(0));
    check("R9 wr_valid after reset", 128'(wr_valid), 128'(0));
    check("R9 st_ready after reset", 128'(st_ready), 128'(1));
    @(posedge clk); #1;
  endtask

  // R1, R2: lone store, odd low address bits, sparse enables
  task automatic t_single();
    logic [LB*8-1:0] d = '0; logic [LB-1:0] m = '0;
    logic [ADDR_W-1:0] a = mk(25'h0_1234, 11, 5);
    int base = ncap;
    wr_ready = 1'b1;
    put(a, 64'h8877_6655_4433_2211, 8'b1010_0101);
    add_exp(d, m, a, 64'h8877_6655_4433_2211, 8'b1010_0101);
    drain();
    check("R2 single write count", 128'(ncap - base), 128'(1));
    chk_wr("R1 single", base, 25'h0_1234, d, m);
  endtask

  // R6: back-to-back stores, port free, fold into the entry leaving
  task automatic t_back2back();
    logic [LB*8-1:0] d = '0; logic [LB-1:0] m = '0;
    int base = ncap;
    wr_ready = 1'b1;
    put(mk(25'h00AB, 1, 0), 64'h1111_2222_3333_4444, 8'hFF);
    put(mk(25'h00AB, 2, 0), 64'h5555_6666_7777_8888, 8'h3C);
    add_exp(d, m, mk(25'h00AB, 1, 0), 64'h1111_2222_3333_4444, 8'hFF);
    add_exp(d, m, mk(25'h00AB, 2, 0), 64'h5555_6666_7777_8888, 8'h3C);
    drain();
    check("R6 one write for two stores", 128'(ncap - base), 128'(1));
    chk_wr("R6 merged", base, 25'h00AB, d, m);
  endtask

  // R3, R4, R5: stalled port, overlap, disjoint and draining-line stores
  task automatic t_gather();
    logic [LB*8-1:0] dx = '0, dy = '0, dx2 = '0;
    logic [LB-1:0]   mx = '0, my = '0, mx2 = '0;
    int base = ncap;
    wr_ready = 1'b0;
    put(mk(25'h0100, 3, 0), 64'hA0A1_A2A3_A4A5_A6A7, 8'hFF);
    add_exp(dx, mx, mk(25'h0100, 3, 0), 64'hA0A1_A2A3_A4A5_A6A7, 8'hFF);
    put(mk(25'h0200, 0, 0), 64'hB0B1_B2B3_B4B5_B6B7, 8'hFF);
    add_exp(dy, my, mk(25'h0200, 0, 0), 64'hB0B1_B2B3_B4B5_B6B7, 8'hFF);
    put(mk(25'h0200, 0, 0), 64'hC0C1_C2C3_C4C5_C6C7, 8'h0F);
    add_exp(dy, my, mk(25'h0200, 0, 0), 64'hC0C1_C2C3_C4C5_C6C7, 8'h0F);
    put(mk(25'h0200, 15, 0), 64'hD0D1_D2D3_D4D5_D6D7, 8'h81);
    add_exp(dy, my, mk(25'h0200, 15, 0), 64'hD0D1_D2D3_D4D5_D6D7, 8'h81);
    put(mk(25'h0100, 3, 0), 64'hE0E1_E2E3_E4E5_E6E7, 8'hF0);
    add_exp(dx2, mx2, mk(25'h0100, 3, 0), 64'hE0E1_E2E3_E4E5_E6E7, 8'hF0);
    @(negedge clk);
    check("R5 draining write untouched mask", wr_mask, mx);
    @(posedge clk); #1;
    drain();
    check("R3 write count", 128'(ncap - base), 128'(3));
    chk_wr("R5 first line", base, 25'h0100, dx, mx);
    chk_wr("R4 merged line", base + 1, 25'h0200, dy, my);
    chk_wr("R5 reopened line", base + 2, 25'h0100, dx2, mx2);
  endtask

  // R7, R8: fill to capacity, refused and accepted stores, order
  task automatic t_full();
    logic [LB*8-1:0] d [5];
    logic [LB-1:0]   m [5];
    int base = ncap;
    wr_ready = 1'b0;
    for (int k = 0; k < 5; k++) begin
      d[k] = '0; m[k] = '0;
      put(mk(25'h0300 + 25'(k), k, 0), 64'h0101_0101_0101_0101 * 64'(k + 1), 8'hFF);
      add_exp(d[k], m[k], mk(25'h0300 + 25'(k), k, 0), 64'h0101_0101_0101_0101 * 64'(k + 1), 8'hFF);
    end
    @(negedge clk);
    check("R8 full when all entries used", 128'(full), 128'(1));
    check("R9 not empty when full", 128'(empty), 128'(0));
    @(posedge clk); #1;
    st_valid = 1'b1; st_addr = mk(25'h0399, 0, 0); st_data = 64'hDEAD_DEAD_DEAD_DEAD; st_be = 8'hFF;
    @(negedge clk);
    check("R8 new line refused when full", 128'(st_ready), 128'(0));
    @(posedge clk); #1;
    st_addr = mk(25'h0302, 9, 0); st_data = 64'h7777_7777_7777_7777; st_be = 8'h18;
    @(negedge clk);
    check("R8 hit accepted when full", 128'(st_ready), 128'(1));
    @(posedge clk); #1;
    st_valid = 1'b0;
    add_exp(d[2], m[2], mk(25'h0302, 9, 0), 64'h7777_7777_7777_7777, 8'h18);
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check("R7 stalled write holds line", 128'(wr_line), 128'(25'h0300));
    check("R7 stalled write valid", 128'(wr_valid), 128'(1));
    @(posedge clk); #1;
    drain();
    check("R8 refused store left no write", 128'(ncap - base), 128'(5));
    for (int k = 0; k < 5; k++)
      chk_wr($sformatf("R7 order %0d", k), base + k, 25'h0300 + 25'(k), d[k], m[k]);
    @(negedge clk);
    check("R9 empty after drain", 128'(empty), 128'(1));
    check("R8 not full after drain", 128'(full), 128'(0));
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_single();
    t_back2back();
    t_gather();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule